// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block caches page translations for a 32-bit virtual address space divided into 4 KB pages. A lookup presents a virtual address together with the kind of access (write or read, user or supervisor). The block takes the low bits of the virtual page number as a set index and the upper bits as a tag. It compares all four ways of that set in parallel. One cycle later it returns either a hit, carrying the physical address and the stored permission flags, or a miss.

On a miss, the page walker that sits beside the block fetches the translation and installs it through the fill port. Two flush commands drop cached translations:
- One removes every entry.
- The other spares entries flagged global.

Replacement inside a set uses a three-bit tree pseudo-LRU per set. An empty way is always taken before the tree is consulted.

Top module: `tlb_xlate`

## Requirements
- R1: Address split and hit. The page offset is `vaddr[11:0]`, the set index is `vaddr[15:12]` and the tag is `vaddr[31:16]`. A hit needs a valid entry in the indexed set whose tag equals the incoming tag. On a hit, `resp_paddr` is the stored physical page number followed by the unchanged 12-bit offset.
- R2: Response timing. The response registers one cycle after `req_valid`. `resp_valid` follows `req_valid` by exactly one cycle. `resp_hit` and `resp_miss` are never high together and never high without `resp_valid`. On a miss, `resp_paddr` and `resp_perm` are zero.
- R3: `resp_perm` returns the stored flags with the following bit meanings:
  - bit 0: writable
  - bit 1: user accessible
  - bit 2: write-through
  - bit 3: cache disabled
  - bit 4: dirty
  - bit 5: global
- R4: `resp_denied` is high only on a hit, and only when one of these holds:
  - `req_write` is set while bit 0 is clear;
  - `req_user` is set while bit 1 is clear.
- R5: Fill placement. A fill whose page number is already cached overwrites that way. Otherwise the fill takes the lowest-numbered invalid way of its set, so four distinct fills to an empty set all stay resident.
- R6: Replacement in a full set follows a tree pseudo-LRU. The tree is updated on every lookup hit and every fill, and it points away from the way just used.
- R7: `flush_nonglobal` invalidates every entry whose global flag (bit 5) is clear. Global entries stay resident.
- R8: `flush_all` invalidates every entry, whatever its global flag.
- R9: Same-cycle ordering.
  - A lookup sees the contents as they were before the fill or flush issued in its own cycle.
  - A fill issued together with a flush takes effect after the flush and survives it.
- R10: After reset, no entry is valid and `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Translation found |
| resp_miss | output | 1 | Translation absent |
| resp_paddr | output | 32 | Physical address (zero on miss) |
| resp_perm | output | 6 | Stored permission flags (zero on miss) |
| resp_denied | output | 1 | Hit whose flags forbid this access |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_perm | input | 6 | Flags to install |
| flush_nonglobal | input | 1 | Invalidate non-global entries |
| flush_all | input | 1 | Invalidate all entries |

## Verification
The risky overlap is a lookup landing in the same cycle as a fill or a flush, since both touch the same set state on one edge.

The bench provokes three such overlaps:
- a lookup and a fill of the same page together, which must still report a miss;
- a lookup together with a flush of all entries, which must still hit on the old contents;
- a fill together with a flush of all entries, whose new entry must be found by the next lookup.

Each case is judged by the response to the colliding lookup and by a follow-up lookup one cycle later.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PPN_W     = 20,
  parameter int SET_BITS  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [VA_W-1:0]            req_vaddr,
  input  logic                       req_write,
  input  logic                       req_user,
  output logic                       resp_valid,
  output logic                       resp_hit,
  output logic                       resp_miss,
  output logic [PPN_W+PAGE_BITS-1:0] resp_paddr,
  output logic [5:0]                 resp_perm,
  output logic                       resp_denied,
  input  logic                       fill_valid,
  input  logic [VA_W-PAGE_BITS-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]           fill_ppn,
  input  logic [5:0]                 fill_perm,
  input  logic                       flush_nonglobal,
  input  logic                       flush_all
);
  localparam int WAYS   = 4;
  localparam int VPN_W  = VA_W - PAGE_BITS;
  localparam int TAG_W  = VPN_W - SET_BITS;
  localparam int SETS   = 1 << SET_BITS;
  localparam int GLB    = 5;

  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q  [SETS][WAYS];
  logic [5:0]       perm_q [SETS][WAYS];
  logic [2:0]       plru_q [SETS];

  function automatic logic [1:0] first_set(input logic [WAYS-1:0] v);
    logic [1:0] r = 2'd0;
    for (int i = WAYS - 1; i >= 0; i--) if (v[i]) r = 2'(i);
    return r;
  endfunction

  function automatic logic [2:0] touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] r = t;
    r[0] = ~w[1];
    if (!w[1]) r[1] = ~w[0];
    else       r[2] = ~w[0];
    return r;
  endfunction

  function automatic logic [1:0] victim(input logic [2:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  wire [SET_BITS-1:0] l_set = req_vaddr[PAGE_BITS +: SET_BITS];
  wire [TAG_W-1:0]    l_tag = req_vaddr[VA_W-1 -: TAG_W];
  wire [SET_BITS-1:0] f_set = fill_vpn[SET_BITS-1:0];
  wire [TAG_W-1:0]    f_tag = fill_vpn[VPN_W-1 -: TAG_W];

  logic [WAYS-1:0] l_hitv, f_match;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign l_hitv[w]  = valid_q[l_set][w] && (tag_q[l_set][w] == l_tag);
    assign f_match[w] = valid_q[f_set][w] && (tag_q[f_set][w] == f_tag);
  end

  wire             l_hit = |l_hitv;
  wire [1:0]       l_way = first_set(l_hitv);
  wire [WAYS-1:0]  f_inv = ~valid_q[f_set];
  wire [1:0]       f_way = |f_match ? first_set(f_match)
                         : |f_inv   ? first_set(f_inv)
                         :            victim(plru_q[f_set]);
  wire             sel   = req_valid && l_hit;
  wire [5:0]       l_perm = perm_q[l_set][l_way];
  wire             deny  = (req_write && !l_perm[0]) || (req_user && !l_perm[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int s = 0; s < SETS; s++) plru_q[s] <= 3'd0;
    end else begin
      if (sel) plru_q[l_set] <= touch(plru_q[l_set], l_way);
      if (fill_valid) plru_q[f_set] <= touch(plru_q[f_set], f_way);
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          if (flush_all || (flush_nonglobal && !perm_q[s][w][GLB]))
            valid_q[s][w] <= 1'b0;
      if (fill_valid) valid_q[f_set][f_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_q[f_set][f_way]  <= f_tag;
      ppn_q[f_set][f_way]  <= fill_ppn;
      perm_q[f_set][f_way] <= fill_perm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_miss   <= 1'b0;
      resp_paddr  <= '0;
      resp_perm   <= '0;
      resp_denied <= 1'b0;
    end else begin
      resp_valid  <= req_valid;
      resp_hit    <= sel;
      resp_miss   <= req_valid && !l_hit;
      resp_paddr  <= sel ? {ppn_q[l_set][l_way], req_vaddr[PAGE_BITS-1:0]} : '0;
      resp_perm   <= sel ? l_perm : '0;
      resp_denied <= sel && deny;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PPN_W     = 20,
  parameter int SET_BITS  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic [VA_W-1:0]            req_vaddr,
  input logic                       resp_valid,
  input logic                       resp_hit,
  input logic                       resp_miss,
  input logic [PPN_W+PAGE_BITS-1:0] resp_paddr,
  input logic [5:0]                 resp_perm,
  input logic                       resp_denied,
  input logic                       fill_valid,
  input logic                       flush_all,
  input logic [(4<<SET_BITS)-1:0]   vld
);
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_hit && resp_miss) && ((resp_hit || resp_miss) == resp_valid));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_miss |-> (resp_paddr == '0 && resp_perm == '0));

  p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!resp_hit || resp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));

  p_denied_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_denied |-> resp_hit);

  p_flush_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_valid) |=> (vld == '0));

  p_flush_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && fill_valid) |=> ($countones(vld) == 1));
endmodule

bind tlb_xlate tlb_xlate_chk #(
  .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PPN_W(PPN_W), .SET_BITS(SET_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
  .resp_paddr(resp_paddr), .resp_perm(resp_perm), .resp_denied(resp_denied),
  .fill_valid(fill_valid), .flush_all(flush_all), .vld(valid_q)
);

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
module tlb_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        resp_valid, resp_hit, resp_miss, resp_denied;
  logic [31:0] resp_paddr;
  logic [5:0]  resp_perm;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [5:0]  fill_perm = '0;
  logic        flush_nonglobal = 1'b0, flush_all = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_paddr(resp_paddr),
    .resp_perm(resp_perm), .resp_denied(resp_denied), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .flush_nonglobal(flush_nonglobal), .flush_all(flush_all)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [19:0] ppn;
    logic [5:0]  perm;
    logic        wr;
    logic        usr;
    logic        ehit;
    logic [31:0] epa;
    logic [5:0]  eperm;
    logic        eden;
  } vec_t;

  localparam logic [1:0] K_LOOK = 2'd0, K_FILL = 2'd1, K_FNG = 2'd2, K_FALL = 2'd3;

  localparam vec_t VEC [13] = '{
    '{K_LOOK, 32'h1234_5678, 20'h0,     6'h00, 1'b0, 1'b0, 1'b0, 32'h0,         6'h00, 1'b0},
    '{K_FILL, 32'h1234_5000, 20'hABCDE, 6'h03, 1'b0, 1'b0, 1'b0, 32'h0,         6'h00, 1'b0},
    '{K_LOOK, 32'h1234_5678, 20'h0,     6'h00, 1'b1, 1'b1, 1'b1, 32'hABCD_E678, 6'h03, 1'b0},
    '{K_FILL, 32'h0001_5000, 20'h11111, 6'h20, 1'b0, 1'b0, 1'b0, 32'h0,         6'h00, 1'b0},
    '{K_LOOK, 32'h0001_5004, 20'h0,     6'h00, 1'b1, 1'b0, 1'b1, 32'h1111_1004, 6'h20, 1'b1},
    '{K_LOOK, 32'h0001_5004, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 32'h1111_1004, 6'h20, 1'b1},
    '{K_LOOK, 32'h0001_5004, 20'h0,     6'h00, 1'b0, 1'b0, 1'b1, 32'h1111_1004, 6'h20, 1'b0},
    '{K_LOOK, 32'h2234_5000, 20'h0,     6'h00, 1'b0, 1'b0, 1'b0, 32'h0,         6'h00, 1'b0},
    '{K_FNG,  32'h0,         20'h0,     6'h00, 1'b0, 1'b0, 1'b0, 32'h0,         6'h00, 1'b0},
    '{K_LOOK, 32'h1234_5678, 20'h0,     6'h00, 1'b0, 1'b0, 1'b0, 32'h0,         6'h00, 1'b0},
    '{K_LOOK, 32'h0001_5ABC, 20'h0,     6'h00, 1'b0, 1'b0, 1'b1, 32'h1111_1ABC, 6'h20, 1'b0},
    '{K_FALL, 32'h0,         20'h0,     6'h00, 1'b0, 1'b0, 1'b0, 32'h0,         6'h00, 1'b0},
    '{K_LOOK, 32'h0001_5004, 20'h0,     6'h00, 1'b0, 1'b0, 1'b0, 32'h0,         6'h00, 1'b0}
  };

  task automatic judge(input string rq, input logic ehit, input logic [31:0] epa,
                       input logic [5:0] eperm, input logic eden);
    logic ok;
    ok = resp_valid && (resp_hit == ehit) && (resp_miss == !ehit) &&
         (resp_paddr == epa) && (resp_perm == eperm) && (resp_denied == eden);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got v%0b h%0b m%0b pa=%h perm=%h den=%0b expected v1 h%0b m%0b pa=%h perm=%h den=%0b",
               rq, resp_valid, resp_hit, resp_miss, resp_paddr, resp_perm, resp_denied,
               ehit, !ehit, epa, eperm, eden);
    end
  endtask

  task automatic look(input logic [31:0] a, input logic wr, input logic usr, input string rq,
                      input logic ehit, input logic [31:0] epa, input logic [5:0] eperm,
                      input logic eden);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = a; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    judge(rq, ehit, epa, eperm, eden);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [5:0] perm);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_perm = perm;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic flush(input logic all);
    @(negedge clk);
    if (all) flush_all = 1'b1; else flush_nonglobal = 1'b1;
    @(negedge clk);
    flush_all = 1'b0; flush_nonglobal = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog got no completion expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0 || resp_hit !== 1'b0 || resp_miss !== 1'b0) begin
      errors++;
      $display("FAIL R10 got v%0b h%0b m%0b expected v0 h0 m0", resp_valid, resp_hit, resp_miss);
    end
    look(32'hFFFF_F123, 1'b0, 1'b0, "R10 empty after reset", 1'b0, 32'h0, 6'h0, 1'b0);

    // table walk: R1 R2 R3 R4 R7 R8
    for (int i = 0; i < 13; i++) begin
      case (VEC[i].kind)
        K_FILL: fill(VEC[i].addr[31:12], VEC[i].ppn, VEC[i].perm);
        K_FNG:  flush(1'b0);
        K_FALL: flush(1'b1);
        default: look(VEC[i].addr, VEC[i].wr, VEC[i].usr, "R1/R3/R4/R7/R8 vector",
                      VEC[i].ehit, VEC[i].epa, VEC[i].eperm, VEC[i].eden);
      endcase
    end

    // R5: four fills to an empty set all stay resident
    for (int i = 0; i < 5; i++) fill(20'h00003 + 20'(i * 16), 20'h10000 + 20'(i), 6'h03);
    // R6: fifth fill evicted way 0
    look(32'h0000_3000, 1'b0, 1'b0, "R6 oldest evicted", 1'b0, 32'h0, 6'h0, 1'b0);
    look(32'h0001_3000, 1'b0, 1'b0, "R5 way1 kept", 1'b1, 32'h1000_1000, 6'h03, 1'b0);
    look(32'h0002_3000, 1'b0, 1'b0, "R5 way2 kept", 1'b1, 32'h1000_2000, 6'h03, 1'b0);
    look(32'h0003_3000, 1'b0, 1'b0, "R5 way3 kept", 1'b1, 32'h1000_3000, 6'h03, 1'b0);
    look(32'h0004_3000, 1'b0, 1'b0, "R6 new entry", 1'b1, 32'h1000_4000, 6'h03, 1'b0);
    fill(20'h00053, 20'h10005, 6'h03);
    look(32'h0002_3000, 1'b0, 1'b0, "R6 hit-ordered victim", 1'b0, 32'h0, 6'h0, 1'b0);
    look(32'h0005_3000, 1'b0, 1'b0, "R6 replacement", 1'b1, 32'h1000_5000, 6'h03, 1'b0);
    fill(20'h00013, 20'h55555, 6'h01);
    look(32'h0001_3ABC, 1'b0, 1'b0, "R5 refill overwrites", 1'b1, 32'h5555_5ABC, 6'h01, 1'b0);
    look(32'h0004_3000, 1'b0, 1'b0, "R5 refill spared others", 1'b1, 32'h1000_4000, 6'h03, 1'b0);

    // R9: lookup and fill of the same page in one cycle
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0007_7000; req_write = 1'b0; req_user = 1'b0;
    fill_valid = 1'b1; fill_vpn = 20'h00077; fill_ppn = 20'h77777; fill_perm = 6'h03;
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0;
    judge("R9 lookup with fill sees old", 1'b0, 32'h0, 6'h0, 1'b0);
    look(32'h0007_7000, 1'b0, 1'b0, "R9 fill visible next", 1'b1, 32'h7777_7000, 6'h03, 1'b0);

    // R9: lookup alongside flush_all
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0007_7010; flush_all = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; flush_all = 1'b0;
    judge("R9 lookup with flush sees old", 1'b1, 32'h7777_7010, 6'h03, 1'b0);
    look(32'h0007_7010, 1'b0, 1'b0, "R8 flushed", 1'b0, 32'h0, 6'h0, 1'b0);

    // R9: fill alongside flush_all survives
    @(negedge clk);
    flush_all = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h00088; fill_ppn = 20'h88888; fill_perm = 6'h02;
    @(negedge clk);
    flush_all = 1'b0; fill_valid = 1'b0;
    look(32'h0008_8FFF, 1'b1, 1'b1, "R9 fill survives flush", 1'b1, 32'h8888_8FFF, 6'h02, 1'b1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule